// File: doc/BRIEF.md
# Vertical Blanking and Sandcastle Encoder

This block derives the vertical timing pulses of a television deflection controller from the count of its vertical divider. The divider runs at twice the line rate, so one line spans two counts. On each divider reset strobe the block opens a vertical blanking pulse and a sawtooth charge window. It also opens an anti-top-flutter pulse, whose start point depends on the current divider mode. Each pulse closes when the half-line count reaches an end value, and that end value depends on the 50/60 Hz selection.

The block combines these pulses with a horizontal flyback flag, a burst-key gate and two vertical-guard fault flags into a two-bit level code. An analog stage downstream turns that code into a three-level sandcastle voltage. Every output is registered. Each output reflects the inputs presented on the previous rising clock edge.

Top module: `vbsc_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is 0 after that edge.
- R2: `vblank_o` is high from the cycle after a `div_reset` strobe until the cycle after the half-line count equals 44 (`sel_60hz`=0) or 34 (`sel_60hz`=1). During that time the anti-top-flutter pulse and the guard flags do not hold it.
- R3: In search mode (`div_mode`=00), a `div_reset` strobe starts `atf_o` in the next cycle, and `first_eq` has no effect on `atf_o`.
- R4: In narrow (01) and standard (10) modes, `first_eq` starts `atf_o` in the next cycle, and `div_reset` does not start it. Code 11 behaves as standard.
- R5: `atf_o` goes low in the cycle after the half-line count equals 8 (`sel_60hz`=0) or 10 (`sel_60hz`=1).
- R6: `vblank_o` is the OR of the anti-top-flutter pulse and the blanking pulse, so `atf_o` high implies `vblank_o` high in the same cycle.
- R7: While `guard_low` or `guard_high` is high, `vblank_o` is high one cycle later, whatever the count.
- R8: `charge_o` goes high in the cycle after a `div_reset` strobe. It goes low in the cycle after the half-line count equals 26.
- R9: `level_o` encodes 00 none, 01 vertical blanking, 10 horizontal blanking (`flyback` high) and 11 burst-key (`burst_gate` high). Burst-key has the highest priority, then horizontal blanking, then vertical blanking.
- R10: When a start strobe and the end count of the same pulse occur in one cycle, the start wins and the pulse is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hl_count | input | CNT_W | Vertical divider half-line count |
| div_reset | input | 1 | Divider reset strobe |
| div_mode | input | 2 | Divider mode: 00 search, 01 narrow, 10 standard, 11 as standard |
| sel_60hz | input | 1 | 1 selects 60 Hz end counts, 0 selects 50 Hz |
| first_eq | input | 1 | First equalizing pulse strobe |
| flyback | input | 1 | Horizontal flyback flag |
| burst_gate | input | 1 | Burst-key gate |
| guard_low | input | 1 | Vertical feedback below low limit |
| guard_high | input | 1 | Vertical feedback above high limit |
| atf_o | output | 1 | Anti-top-flutter pulse |
| vblank_o | output | 1 | Vertical blanking pulse |
| charge_o | output | 1 | Sawtooth charge-enable window |
| level_o | output | 2 | Sandcastle level code |

## Verification
Two events can fall in the same cycle: a divider reset strobe, and the end count of a pulse that is still running. When they coincide, the start must win. The bench provokes this collision in two places. It presents a reset strobe at count 34 while 60 Hz blanking is active, and at count 8 while in search mode at 50 Hz. In both cases it expects the pulses to stay high after the edge instead of dropping. A second overlap, burst gate against a guard-forced vertical blanking, is judged by requiring level 11 while `vblank_o` stays high.

// File: rtl/vbsc_pkg.sv
// Shared types for the vertical blanking / sandcastle encoder.
// Assumes a two-bit mode field driven by the vertical divider.
package vbsc_pkg;

    typedef enum logic [1:0] {
        MODE_SEARCH   = 2'b00,
        MODE_NARROW   = 2'b01,
        MODE_STANDARD = 2'b10,
        MODE_SPARE    = 2'b11
    } div_mode_e;

    typedef enum logic [1:0] {
        LVL_NONE   = 2'b00,
        LVL_VBLANK = 2'b01,
        LVL_HBLANK = 2'b10,
        LVL_BURST  = 2'b11
    } sc_level_e;

endpackage

// File: rtl/vbsc_window.sv
// Count-terminated window register.
// It opens the cycle after start_i and closes the cycle after count_i equals
// the end value chosen by sel_60hz_i. A start always beats a close in the
// same cycle. It assumes the count advances one step at a time, so the
// end value is never skipped in normal use.
module vbsc_window #(
    parameter int CNT_W  = 10,
    parameter int END_50 = 8,
    parameter int END_60 = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             sel_60hz_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             win_nxt_o,
    output logic             win_o
);

    localparam logic [CNT_W-1:0] STOP_50 = CNT_W'(END_50);
    localparam logic [CNT_W-1:0] STOP_60 = CNT_W'(END_60);

    logic stop_hit;

    // Decide next window state: start has priority over the end count.
    always_comb begin
        stop_hit = (count_i == (sel_60hz_i ? STOP_60 : STOP_50));
        if (start_i)
            win_nxt_o = 1'b1;
        else if (stop_hit)
            win_nxt_o = 1'b0;
        else
            win_nxt_o = win_o;
    end

    // Hold the window state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_o <= 1'b0;
        else
            win_o <= win_nxt_o;
    end

endmodule

// File: rtl/vbsc_level_enc.sv
// Registered priority encoder for the sandcastle level code.
// Burst-key beats horizontal blanking, which beats vertical blanking.
// It assumes its request inputs are already aligned to the same cycle.
module vbsc_level_enc
    import vbsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vblank_req,
    input  logic       hblank_req,
    input  logic       burst_req,
    output logic [1:0] level_o
);

    sc_level_e level_nxt;

    // Choose the highest-priority active level.
    always_comb begin
        if (burst_req)
            level_nxt = LVL_BURST;
        else if (hblank_req)
            level_nxt = LVL_HBLANK;
        else if (vblank_req)
            level_nxt = LVL_VBLANK;
        else
            level_nxt = LVL_NONE;
    end

    // Register the level code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_o <= LVL_NONE;
        else
            level_o <= level_nxt;
    end

endmodule

// File: rtl/vbsc_top.sv
// Vertical blanking and sandcastle encoder top.
// From the vertical divider count it builds the anti-top-flutter pulse, the
// blanking pulse, the sawtooth charge window and the two-bit sandcastle
// level. It assumes that div_reset and first_eq are single-cycle strobes and
// that the guard flags are already synchronous to clk.
module vbsc_top
    import vbsc_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int ATF_END_50 = 8,
    parameter int ATF_END_60 = 10,
    parameter int BLK_END_50 = 44,
    parameter int BLK_END_60 = 34,
    parameter int CHARGE_LEN = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] hl_count,
    input  logic             div_reset,
    input  logic [1:0]       div_mode,
    input  logic             sel_60hz,
    input  logic             first_eq,
    input  logic             flyback,
    input  logic             burst_gate,
    input  logic             guard_low,
    input  logic             guard_high,
    output logic             atf_o,
    output logic             vblank_o,
    output logic             charge_o,
    output logic [1:0]       level_o
);

    div_mode_e mode;
    logic      atf_start;
    logic      atf_nxt;
    logic      blk_nxt;
    logic      blk_q;
    logic      chg_nxt;
    logic      guard_fault;
    logic      vblank_nxt;

    // Pick the anti-top-flutter start source from the divider mode.
    always_comb begin
        mode = div_mode_e'(div_mode);
        case (mode)
            MODE_SEARCH: atf_start = div_reset;
            default:     atf_start = first_eq;
        endcase
    end

    vbsc_window #(
        .CNT_W (CNT_W),
        .END_50(ATF_END_50),
        .END_60(ATF_END_60)
    ) u_atf (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (atf_start),
        .sel_60hz_i(sel_60hz),
        .count_i   (hl_count),
        .win_nxt_o (atf_nxt),
        .win_o     (atf_o)
    );

    vbsc_window #(
        .CNT_W (CNT_W),
        .END_50(BLK_END_50),
        .END_60(BLK_END_60)
    ) u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (div_reset),
        .sel_60hz_i(sel_60hz),
        .count_i   (hl_count),
        .win_nxt_o (blk_nxt),
        .win_o     (blk_q)
    );

    vbsc_window #(
        .CNT_W (CNT_W),
        .END_50(CHARGE_LEN),
        .END_60(CHARGE_LEN)
    ) u_charge (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (div_reset),
        .sel_60hz_i(sel_60hz),
        .count_i   (hl_count),
        .win_nxt_o (chg_nxt),
        .win_o     (charge_o)
    );

    // Merge both pulses and the guard override into the next vertical blank.
    always_comb begin
        guard_fault = guard_low | guard_high;
        vblank_nxt  = atf_nxt | blk_nxt | guard_fault;
    end

    // Register the vertical blanking output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vblank_o <= 1'b0;
        else
            vblank_o <= vblank_nxt;
    end

    vbsc_level_enc u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .vblank_req(vblank_nxt),
        .hblank_req(flyback),
        .burst_req (burst_gate),
        .level_o   (level_o)
    );

endmodule

// File: rtl/vbsc_chk.sv
// Property checker for vbsc_top, attached through bind.
// It observes the top ports only and assumes the default end counts of
// the block.
module vbsc_chk #(
    parameter int CNT_W      = 10,
    parameter int ATF_END_50 = 8,
    parameter int ATF_END_60 = 10,
    parameter int CHARGE_LEN = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] hl_count,
    input logic             div_reset,
    input logic [1:0]       div_mode,
    input logic             sel_60hz,
    input logic             first_eq,
    input logic             flyback,
    input logic             burst_gate,
    input logic             guard_low,
    input logic             guard_high,
    input logic             atf_o,
    input logic             vblank_o,
    input logic             charge_o,
    input logic [1:0]       level_o
);

    logic search_m;
    assign search_m = (div_mode == 2'b00);

    AST_BLANK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        div_reset |=> vblank_o); // R2
    AST_ATF_SEARCH_START: assert property (@(posedge clk) disable iff (!rst_n)
        (search_m && div_reset) |=> atf_o); // R3
    AST_ATF_SEARCH_EQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (search_m && first_eq && !div_reset && !atf_o) |=> !atf_o); // R3
    AST_ATF_EQ_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!search_m && first_eq) |=> atf_o); // R4
    AST_ATF_END_50: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_60hz && hl_count == CNT_W'(ATF_END_50) && !(search_m ? div_reset : first_eq)) |=> !atf_o); // R5
    AST_ATF_END_60: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_60hz && hl_count == CNT_W'(ATF_END_60) && !(search_m ? div_reset : first_eq)) |=> !atf_o); // R5
    AST_VBLANK_COVERS_ATF: assert property (@(posedge clk) disable iff (!rst_n)
        atf_o |-> vblank_o); // R6
    AST_GUARD_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_low || guard_high) |=> vblank_o); // R7
    AST_CHARGE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        div_reset |=> charge_o); // R8
    AST_CHARGE_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_reset && hl_count == CNT_W'(CHARGE_LEN)) |=> !charge_o); // R8
    AST_LEVEL_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        burst_gate |=> (level_o == 2'b11)); // R9
    AST_LEVEL_HBLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (flyback && !burst_gate) |=> (level_o == 2'b10)); // R9
    AST_LEVEL_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (!flyback && !burst_gate && (guard_low || guard_high)) |=> (level_o == 2'b01)); // R9
    AST_LEVEL_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == 2'b00) |-> !vblank_o); // R9

endmodule

bind vbsc_top vbsc_chk #(
    .CNT_W     (CNT_W),
    .ATF_END_50(ATF_END_50),
    .ATF_END_60(ATF_END_60),
    .CHARGE_LEN(CHARGE_LEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hl_count  (hl_count),
    .div_reset (div_reset),
    .div_mode  (div_mode),
    .sel_60hz  (sel_60hz),
    .first_eq  (first_eq),
    .flyback   (flyback),
    .burst_gate(burst_gate),
    .guard_low (guard_low),
    .guard_high(guard_high),
    .atf_o     (atf_o),
    .vblank_o  (vblank_o),
    .charge_o  (charge_o),
    .level_o   (level_o)
);

// File: tb/vbsc_top_tb.sv
`timescale 1ns/1ps
// Self-checking bench for vbsc_top: a vector table, then directed tests.
module vbsc_top_tb;

    localparam int CNT_W = 10;
    localparam int NVEC  = 27;

    // Fields: count, reset strobe, mode, 60Hz, first_eq, flyback, burst,
    // {guard_low,guard_high}, expected {atf,vblank,charge}, expected level.
    localparam logic [23:0] VEC [NVEC] = '{
        {10'd0,  1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 3'b111, 2'd1}, // R2 R3 R8 start
        {10'd1,  1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 3'b111, 2'd1},
        {10'd7,  1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 3'b111, 2'd1},
        {10'd8,  1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 3'b011, 2'd1}, // R5 50Hz end
        {10'd9,  1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 3'b011, 2'd2}, // R9 hblank over vblank
        {10'd10, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 3'b011, 2'd3}, // R9 burst over hblank
        {10'd26, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 3'b010, 2'd1}, // R8 close
        {10'd27, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 3'b010, 2'd1}, // R3 eq ignored
        {10'd44, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 3'b000, 2'd0}, // R2 50Hz end
        {10'd45, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 3'b000, 2'd2},
        {10'd46, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 3'b010, 2'd1}, // R7 high fault
        {10'd47, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 3'b010, 2'd1}, // R7 low fault
        {10'd48, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 3'b000, 2'd0},
        {10'd0,  1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 3'b011, 2'd1}, // R4 reset no atf
        {10'd5,  1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 3'b111, 2'd1}, // R4 eq starts
        {10'd8,  1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 3'b011, 2'd1}, // R5
        {10'd26, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 3'b010, 2'd1}, // R8
        {10'd34, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 3'b000, 2'd0}, // R2 60Hz end
        {10'd0,  1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 3'b111, 2'd1}, // R4 standard
        {10'd8,  1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 3'b111, 2'd1}, // R5 60Hz not yet
        {10'd10, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 3'b011, 2'd1}, // R5 60Hz end
        {10'd20, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 3'b111, 2'd1}, // R4 code 11
        {10'd10, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 3'b011, 2'd1},
        {10'd34, 1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 3'b011, 2'd1}, // R10 start beats end
        {10'd34, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 3'b001, 2'd3},
        {10'd26, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 3'b000, 2'd0},
        {10'd8,  1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 3'b111, 2'd1}  // R10 atf start at end
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] hl_count;
    logic             div_reset, sel_60hz, first_eq, flyback, burst_gate;
    logic             guard_low, guard_high;
    logic [1:0]       div_mode;
    logic             atf_o, vblank_o, charge_o;
    logic [1:0]       level_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    vbsc_top u_dut (
        .clk(clk), .rst_n(rst_n), .hl_count(hl_count), .div_reset(div_reset),
        .div_mode(div_mode), .sel_60hz(sel_60hz), .first_eq(first_eq),
        .flyback(flyback), .burst_gate(burst_gate), .guard_low(guard_low),
        .guard_high(guard_high), .atf_o(atf_o), .vblank_o(vblank_o),
        .charge_o(charge_o), .level_o(level_o)
    );

    task automatic check(input string what, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag, input logic [2:0] e3, input logic [1:0] el);
        check({tag, " atf_o R3 R4 R5 R10"}, {1'b0, atf_o},    {1'b0, e3[2]});
        check({tag, " vblank_o R2 R6 R7"},  {1'b0, vblank_o}, {1'b0, e3[1]});
        check({tag, " charge_o R8"},        {1'b0, charge_o}, {1'b0, e3[0]});
        check({tag, " level_o R9"},         level_o,          el);
    endtask

    task automatic drive(input logic [CNT_W-1:0] c, input logic r, input logic [1:0] m,
                         input logic s, input logic e, input logic f, input logic b,
                         input logic [1:0] g);
        @(negedge clk);
        hl_count = c; div_reset = r; div_mode = m; sel_60hz = s; first_eq = e;
        flyback = f; burst_gate = b; guard_low = g[1]; guard_high = g[0];
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0;
        hl_count = '0; div_reset = 0; div_mode = 0; sel_60hz = 0; first_eq = 0;
        flyback = 0; burst_gate = 0; guard_low = 0; guard_high = 0;
        repeat (3) @(posedge clk);
        #1;
        check_all("reset state R1", 3'b000, 2'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][23:14], VEC[i][13], VEC[i][12:11], VEC[i][10], VEC[i][9],
                  VEC[i][8], VEC[i][7], VEC[i][6:5]);
            check_all($sformatf("vec%0d", i), VEC[i][4:2], VEC[i][1:0]);
        end

        // R1: reset in the middle of active pulses clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        div_reset = 1'b0; flyback = 1'b1;
        @(posedge clk);
        #1;
        check_all("mid-pulse reset R1", 3'b000, 2'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R5 R8: full 60 Hz sweep in search mode, counting upward.
        drive(10'd0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
        check_all("sweep60 start R2", 3'b111, 2'd1);
        for (int c = 1; c <= 40; c++) begin
            drive(CNT_W'(c), 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
            check_all($sformatf("sweep60 c%0d R2 R5 R8", c),
                      {(c < 10), (c < 34), (c < 26)}, (c < 34) ? 2'd1 : 2'd0);
        end

        // R7 R9: guard held with burst and flyback; burst wins, blanking stays.
        drive(10'd50, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11);
        check_all("guard+burst R7 R9", 3'b010, 2'd3);
        drive(10'd51, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10);
        check_all("guard held R7", 3'b010, 2'd1);
        drive(10'd52, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
        check_all("guard released R7", 3'b000, 2'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule